// File: doc/BRIEF.md
# Dual Byte Queue with Packed Level Status

This block holds two byte queues between a register bus and a serial engine. The transmit queue is filled by bus writes and emptied by the engine. The receive queue is filled by the engine and drained by bus reads. Each queue has its own control register. That register holds an enable, a flush command that clears itself, and a 6-bit trigger level.

The fill counts of both queues and the transmit free space are packed into one read-only status word. Software uses this word to poll for room before it writes and to find out how many bytes are waiting to be read. Each queue drives a level-based request line to an interrupt unit. The engine sees an overrun pulse whenever a received byte has to be dropped because the receive queue is full.

Top module: `serial_fifo_bank`

## Requirements
- R1: After reset both queues are empty and disabled, both control registers read 0, the status word reads DEPTH in bits 29:24 and 0 elsewhere, and tx_req, rx_req, tx_valid and rx_overrun are all 0.
- R2: The status word (select 4) holds the receive count in bits 5:0, the transmit count in bits 13:8 and the transmit free space in bits 29:24, with all other bits 0. Transmit count plus free space always equals DEPTH (16).
- R3: A bus write to the transmit data register (select 0) appends its low byte only while the transmit queue is enabled and not full. Otherwise the byte is dropped and the counts do not change.
- R4: tx_valid is 1 exactly when the transmit queue is not empty, and tx_byte shows the oldest byte. An engine tx_pop removes that byte, and bytes leave in the order they were written.
- R5: An rx_push appends rx_byte while the receive queue is enabled. A bus read of the receive data register (select 1) with reg_re returns the oldest byte in bits 7:0 and removes it. Reading an empty queue returns 0 and changes nothing.
- R6: An rx_push into a full receive queue with no bus read in the same cycle drops the byte and raises rx_overrun for exactly the next cycle. A push and a read in the same cycle at full are both accepted with no overrun.
- R7: The control registers are at select 2 (transmit) and select 3 (receive). Each holds an enable in bit 0, a flush command in bit 1 that always reads back 0, and a trigger level in bits 13:8. All other bits read 0, and every unused select reads 0.
- R8: A control write with bit 1 set leaves that queue empty in the next cycle, even when a push or pop hits the same queue in that cycle. Clearing the enable and flushing can be done in one write.
- R9: tx_req is 1 exactly when the transmit queue is enabled and its count is at or below its trigger level.
- R10: rx_req is 1 exactly when the receive queue is enabled and its count is at or above its trigger level.
- R11: A push and a pop on the same queue in one cycle leave its count unchanged and keep first-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops the receive queue at select 1) |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current select |
| tx_byte | output | DW | Oldest transmit byte |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_pop | input | 1 | Engine takes the oldest transmit byte |
| rx_byte | input | DW | Received byte from the engine |
| rx_push | input | 1 | Engine delivers rx_byte |
| rx_overrun | output | 1 | One-cycle pulse after a received byte was dropped |
| tx_req | output | 1 | Transmit level request |
| rx_req | output | 1 | Receive level request |

## Verification
Two pairs of functions can fall in the same cycle. The first is a push and a pop on one queue. The bench provokes it with a bus write and an engine pop on the transmit side, and with an engine push and a bus read on a full receive queue. It judges the result by the unchanged count in the status word, by the byte order seen afterwards, and by rx_overrun staying 0. The second is a flush together with traffic on the same queue: a transmit flush lands in the same cycle as a tx_pop, and a receive flush in the same cycle as an rx_push. Both must leave the count at 0 and raise no overrun. Request behaviour is swept over every count from 0 to 16 against trigger levels 0 to 20.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
   localparam int REG_W    = 32;
   localparam int SEL_W    = 3;
   localparam int LVL_W    = 6;
   // control register field positions
   localparam int CTL_EN   = 0;
   localparam int CTL_FLU  = 1;
   localparam int CTL_LVL  = 8;
   // status word field positions
   localparam int ST_RXF   = 0;
   localparam int ST_TXF   = 8;
   localparam int ST_TXR   = 24;

   typedef enum logic [SEL_W-1:0] {
      SEL_TXD   = 3'd0,
      SEL_RXD   = 3'd1,
      SEL_TXCTL = 3'd2,
      SEL_RXCTL = 3'd3,
      SEL_STAT  = 3'd4
   } reg_sel_e;

   typedef struct packed {
      logic             en;
      logic [LVL_W-1:0] lvl;
   } qctl_t;
endpackage

// File: rtl/sfb_fifo.sv
module sfb_fifo #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   generate
      if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_depth
         $error("sfb_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          wr_ok, rd_ok;

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
   assign rd_ok = pop && !empty && !flush;
   assign wr_ok = push && (!full || rd_ok) && !flush;
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr + AW'(1);
         if (rd_ok) rd_ptr <= rd_ptr + AW'(1);
         case ({wr_ok, rd_ok})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/sfb_ctl.sv
module sfb_ctl
   import sfb_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             en_in,
   input  logic             flush_in,
   input  logic [LVL_W-1:0] lvl_in,
   output qctl_t            ctl,
   output logic             flush,
   output logic [REG_W-1:0] rdata
);
   assign flush = wr && flush_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctl <= '0;
      else if (wr) ctl <= '{en: en_in, lvl: lvl_in};
   end

   always_comb begin
      rdata                    = '0;
      rdata[CTL_EN]            = ctl.en;
      rdata[CTL_LVL +: LVL_W]  = ctl.lvl;
   end
endmodule

// File: rtl/sfb_status.sv
module sfb_status
   import sfb_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CW    = 5
) (
   input  logic [CW-1:0]    rx_cnt,
   input  logic [CW-1:0]    tx_cnt,
   output logic [REG_W-1:0] word
);
   generate
      if (CW > LVL_W) begin : g_bad_width
         $error("sfb_status: count does not fit a 6-bit field");
      end
   endgenerate

   logic [CW-1:0] tx_room;
   assign tx_room = CW'(DEPTH) - tx_cnt;

   always_comb begin
      word                     = '0;
      word[ST_RXF +: LVL_W]    = LVL_W'(rx_cnt);
      word[ST_TXF +: LVL_W]    = LVL_W'(tx_cnt);
      word[ST_TXR +: LVL_W]    = LVL_W'(tx_room);
   end
endmodule

// File: rtl/serial_fifo_bank.sv
module serial_fifo_bank
   import sfb_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int DW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic             reg_re,
   input  logic [SEL_W-1:0] reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic [DW-1:0]    tx_byte,
   output logic             tx_valid,
   input  logic             tx_pop,
   input  logic [DW-1:0]    rx_byte,
   input  logic             rx_push,
   output logic             rx_overrun,
   output logic             tx_req,
   output logic             rx_req
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   generate
      if (DW < 1 || DW > CTL_LVL) begin : g_bad_dw
         $error("serial_fifo_bank: DW must be 1..8");
      end
      if (DEPTH > 32) begin : g_bad_depth
         $error("serial_fifo_bank: DEPTH above 32 overflows status fields");
      end
   endgenerate

   qctl_t             tx_ctl, rx_ctl;
   logic              tx_en, rx_en, tx_flush, rx_flush;
   logic [REG_W-1:0]  tx_ctl_rd, rx_ctl_rd, stat_word;
   logic [CW-1:0]     tx_cnt, rx_cnt;
   logic              tx_full, tx_empty, rx_full, rx_empty;
   logic [DW-1:0]     rx_head;
   logic              wr_txd, rd_rxd, wr_txctl, wr_rxctl, rx_in;
   logic              unused_wdata;

   assign unused_wdata = ^reg_wdata;

   assign wr_txd   = reg_we && (reg_addr == SEL_TXD);
   assign wr_txctl = reg_we && (reg_addr == SEL_TXCTL);
   assign wr_rxctl = reg_we && (reg_addr == SEL_RXCTL);
   assign rd_rxd   = reg_re && (reg_addr == SEL_RXD);
   assign tx_en    = tx_ctl.en;
   assign rx_en    = rx_ctl.en;
   assign rx_in    = rx_push && rx_en;

   sfb_ctl u_tx_ctl (
      .clk(clk), .rst_n(rst_n), .wr(wr_txctl),
      .en_in(reg_wdata[CTL_EN]), .flush_in(reg_wdata[CTL_FLU]),
      .lvl_in(reg_wdata[CTL_LVL +: LVL_W]),
      .ctl(tx_ctl), .flush(tx_flush), .rdata(tx_ctl_rd)
   );

   sfb_ctl u_rx_ctl (
      .clk(clk), .rst_n(rst_n), .wr(wr_rxctl),
      .en_in(reg_wdata[CTL_EN]), .flush_in(reg_wdata[CTL_FLU]),
      .lvl_in(reg_wdata[CTL_LVL +: LVL_W]),
      .ctl(rx_ctl), .flush(rx_flush), .rdata(rx_ctl_rd)
   );

   sfb_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_q (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush),
      .push(wr_txd && tx_en), .pop(tx_pop), .din(reg_wdata[DW-1:0]),
      .dout(tx_byte), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
   );

   sfb_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_q (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush),
      .push(rx_in), .pop(rd_rxd), .din(rx_byte),
      .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
   );

   sfb_status #(.DEPTH(DEPTH), .CW(CW)) u_status (
      .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .word(stat_word)
   );

   assign tx_valid = !tx_empty;

   // Dropped byte: full, no read to make room, no flush in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_overrun <= 1'b0;
      else        rx_overrun <= rx_in && rx_full && !rd_rxd && !rx_flush;
   end

   assign tx_req = tx_en && (LVL_W'(tx_cnt) <= tx_ctl.lvl);
   assign rx_req = rx_en && (LVL_W'(rx_cnt) >= rx_ctl.lvl);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         SEL_RXD:   if (!rx_empty) reg_rdata[DW-1:0] = rx_head;
         SEL_TXCTL: reg_rdata = tx_ctl_rd;
         SEL_RXCTL: reg_rdata = rx_ctl_rd;
         SEL_STAT:  reg_rdata = stat_word;
         default:   reg_rdata = '0;
      endcase
   end

   logic unused_flags;
   assign unused_flags = tx_full;
endmodule

// File: rtl/sfb_checker.sv
module sfb_checker
   import sfb_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CW    = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic             reg_re,
   input logic [SEL_W-1:0] reg_addr,
   input logic [REG_W-1:0] reg_wdata,
   input logic             rx_push,
   input logic             rx_overrun,
   input logic             tx_req,
   input logic             rx_req,
   input logic             tx_en,
   input logic             rx_en,
   input logic [CW-1:0]    tx_cnt,
   input logic [CW-1:0]    rx_cnt
);
   // R8: flush command empties the transmit queue by the next cycle
   a_r8_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == SEL_TXCTL && reg_wdata[CTL_FLU]) |=> (tx_cnt == '0));

   // R8: flush command empties the receive queue and drops nothing
   a_r8_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == SEL_RXCTL && reg_wdata[CTL_FLU]) |=> (rx_cnt == '0 && !rx_overrun));

   // R6: an overrun pulse follows a push into a full receive queue
   a_r6_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |-> ($past(rx_push) && $past(rx_cnt) == CW'(DEPTH)));

   // R6: a full queue with an unserved push reports overrun
   a_r6_overrun_seen: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_en && rx_cnt == CW'(DEPTH) && !(reg_re && reg_addr == SEL_RXD)
       && !(reg_we && reg_addr == SEL_RXCTL)) |=> rx_overrun);

   // R11: counts move by at most one entry per cycle upward
   a_r11_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (tx_cnt <= $past(tx_cnt) + CW'(1)));

   // R2: counts never exceed the depth
   a_r2_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

   // R9: transmit request only while enabled
   a_r9_tx_req_en: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |-> tx_en);

   // R10: receive request only while enabled
   a_r10_rx_req_en: assert property (@(posedge clk) disable iff (!rst_n)
      rx_req |-> rx_en);
endmodule

bind serial_fifo_bank sfb_checker #(.DEPTH(DEPTH), .CW(CW)) u_sfb_checker (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rx_push(rx_push),
   .rx_overrun(rx_overrun), .tx_req(tx_req), .rx_req(rx_req),
   .tx_en(tx_en), .rx_en(rx_en), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/test_serial_fifo_bank.sv
module test_serial_fifo_bank;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0, reg_re = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [7:0]  tx_byte, rx_byte = '0;
   logic        tx_valid, tx_pop = 1'b0, rx_push = 1'b0;
   logic        rx_overrun, tx_req, rx_req;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #4 clk = ~clk;

   serial_fifo_bank #(.DEPTH(DEPTH), .DW(8)) i_serial_fifo_bank (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_pop(tx_pop),
      .rx_byte(rx_byte), .rx_push(rx_push), .rx_overrun(rx_overrun),
      .tx_req(tx_req), .rx_req(rx_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] stat(input int rx, input int tx);
      return 32'(rx) | (32'(tx) << 8) | (32'(DEPTH - tx) << 24);
   endfunction

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic peek(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; #1 d = reg_rdata;
   endtask

   task automatic pop_rx(output logic [31:0] d);
      @(negedge clk); reg_addr = 3'd1; reg_re = 1'b1; #1 d = reg_rdata;
      @(negedge clk); reg_re = 1'b0;
   endtask

   task automatic eng_push(input logic [7:0] b);
      @(negedge clk); rx_push = 1'b1; rx_byte = b;
      @(negedge clk); rx_push = 1'b0;
   endtask

   task automatic eng_pop();
      @(negedge clk); tx_pop = 1'b1;
      @(negedge clk); tx_pop = 1'b0;
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      peek(3'd4, d); chk("R1 status", d, stat(0, 0));
      peek(3'd2, d); chk("R1 tx ctl", d, 0);
      peek(3'd3, d); chk("R1 rx ctl", d, 0);
      chk("R1 outputs", {28'd0, tx_req, rx_req, tx_valid, rx_overrun}, 0);
      peek(3'd7, d); chk("R7 unused select", d, 0);

      // R3 disabled transmit queue drops writes
      wr(3'd0, 32'h55);
      peek(3'd4, d); chk("R3 disabled push", d, stat(0, 0));

      // R7 control layout; flush reads 0
      wr(3'd2, 32'hFFFF_FFFF & ~32'h2);
      peek(3'd2, d); chk("R7 tx ctl readback", d, 32'h0000_3F01);

      // R2 R3 R9 fill sweep with level sweep
      for (int k = 0; k <= DEPTH; k++) begin
         if (k > 0) wr(3'd0, 32'hA0 + 32'(k - 1));
         peek(3'd4, d); chk("R2 status fill", d, stat(0, k));
         chk("R4 tx_valid", {31'd0, tx_valid}, 32'(k != 0));
         for (int lv = 0; lv <= 20; lv++) begin
            wr(3'd2, (32'(lv) << 8) | 32'h1);
            chk("R9 tx_req", {31'd0, tx_req}, 32'(k <= lv));
         end
      end
      wr(3'd0, 32'hEE);
      peek(3'd4, d); chk("R3 push to full dropped", d, stat(0, DEPTH));

      // R4 order on engine pops
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); chk("R4 tx order", {24'd0, tx_byte}, 32'hA0 + 32'(i));
         eng_pop();
      end
      // R11 simultaneous bus push and engine pop
      @(negedge clk); chk("R11 head before", {24'd0, tx_byte}, 32'hA4);
      reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'hB0; tx_pop = 1'b1;
      @(negedge clk); reg_we = 1'b0; tx_pop = 1'b0;
      peek(3'd4, d); chk("R11 tx count kept", d, stat(0, 12));
      chk("R11 next head", {24'd0, tx_byte}, 32'hA5);

      // R8 transmit flush together with an engine pop
      @(negedge clk); reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h0000_0203; tx_pop = 1'b1;
      @(negedge clk); reg_we = 1'b0; tx_pop = 1'b0;
      peek(3'd4, d); chk("R8 tx flush with pop", d, stat(0, 0));
      peek(3'd2, d); chk("R7 flush reads 0", d, 32'h0000_0201);
      chk("R4 empty after flush", {31'd0, tx_valid}, 0);

      // R5 disabled receive queue ignores pushes
      eng_push(8'h11);
      peek(3'd4, d); chk("R5 disabled rx push", d, stat(0, 0));
      wr(3'd3, 32'h1);

      // R5 R10 fill sweep with level sweep
      for (int k = 0; k <= DEPTH; k++) begin
         if (k > 0) eng_push(8'h50 + 8'(k - 1));
         peek(3'd4, d); chk("R5 rx fill", d, stat(k, 0));
         for (int lv = 0; lv <= 20; lv++) begin
            wr(3'd3, (32'(lv) << 8) | 32'h1);
            chk("R10 rx_req", {31'd0, rx_req}, 32'(k >= lv));
         end
      end

      // R6 overrun on push into full queue
      eng_push(8'hEE);
      chk("R6 overrun pulse", {31'd0, rx_overrun}, 1);
      @(negedge clk); chk("R6 pulse one cycle", {31'd0, rx_overrun}, 0);
      peek(3'd4, d); chk("R6 count held", d, stat(DEPTH, 0));

      // R6 R11 push and read at full: both accepted
      @(negedge clk); reg_addr = 3'd1; reg_re = 1'b1; rx_push = 1'b1; rx_byte = 8'h77;
      #1 chk("R5 head read", reg_rdata, 32'h50);
      @(negedge clk); reg_re = 1'b0; rx_push = 1'b0;
      chk("R6 no overrun with read", {31'd0, rx_overrun}, 0);
      peek(3'd4, d); chk("R11 rx count kept", d, stat(DEPTH, 0));

      // R5 drain order
      for (int i = 0; i < DEPTH; i++) begin
         pop_rx(d);
         chk("R5 rx order", d, (i < DEPTH - 1) ? 32'h51 + 32'(i) : 32'h77);
      end
      pop_rx(d); chk("R5 empty read", d, 0);
      peek(3'd4, d); chk("R5 empty read no change", d, stat(0, 0));

      // R8 receive flush with a simultaneous push
      eng_push(8'h01); eng_push(8'h02);
      @(negedge clk); reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h3; rx_push = 1'b1; rx_byte = 8'h03;
      @(negedge clk); reg_we = 1'b0; rx_push = 1'b0;
      chk("R8 no overrun on flush", {31'd0, rx_overrun}, 0);
      peek(3'd4, d); chk("R8 rx flush with push", d, stat(0, 0));

      // R8 shutdown: clear enable and flush in one write
      eng_push(8'h09);
      wr(3'd0, 32'h44);
      wr(3'd3, 32'h2); wr(3'd2, 32'h2);
      peek(3'd4, d); chk("R8 shutdown flush", d, stat(0, 0));
      chk("R9 R10 reqs off", {30'd0, tx_req, rx_req}, 0);

      done = 1;
      summary();
      $finish;
   end
endmodule